// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned 32-bit integer by another over many clock cycles using the restoring method. A start request loads the operands. The block then runs a fixed number of subtract, test and restore steps, and produces a quotient and a remainder. When the work is finished it raises a one-cycle completion pulse. The results stay on the outputs until the next operation is accepted.

The datapath holds three registers. The remainder register is 64 bits wide and starts as the zero-extended dividend. The divisor register is 64 bits wide, starts with the divisor in its upper half, and moves one bit right per iteration. The quotient register is 32 bits wide and takes one new bit at its low end per iteration.

Each of the 33 iterations takes two cycles, and both cycles use one shared 64-bit adder/subtractor:
- In the first cycle the divisor is subtracted from the remainder, and the difference is written back.
- In the second cycle the sign of that difference is tested. A negative difference is undone by adding the divisor back. The quotient then takes in its new bit and the divisor shifts right.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, busy_o and done_o are 0, and quotient_o and remainder_o are 0.
- R2: When start_i is 1 while busy_o is 0, the operands are captured at that clock edge and busy_o is 1 from the next cycle.
- R3: An accepted operation takes 66 cycles (33 iterations of two cycles each). busy_o stays 1 for exactly those 66 cycles, and done_o is 1 in the cycle after them.
- R4: done_o is a single-cycle pulse, and busy_o is 0 whenever done_o is 1.
- R5: For a non-zero divisor, quotient_o equals floor(dividend / divisor) when done_o is 1.
- R6: For a non-zero divisor, remainder_o equals dividend mod divisor when done_o is 1.
- R7: A start_i pulse while busy_o is 1 is ignored. The running operation keeps its operands and its timing.
- R8: A divisor of zero gives quotient_o = 0xFFFFFFFF and remainder_o = dividend. There is no error indication.
- R9: quotient_o and remainder_o hold their values from done_o until the next accepted start, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; sampled only when idle |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quotient_o | output | 32 | Quotient result |
| remainder_o | output | 32 | Remainder result |

## Verification
Counting from the edge that accepts start_i:
- busy_o is due one cycle later.
- done_o and both results are due 66 cycles later.
- done_o must be low again one cycle after that.

The bench drives start_i half a cycle before the accepting edge. It then counts rising edges and samples at the falling edge in each of these windows. It also samples just before done_o, to confirm that done_o is still low and busy_o still high. A start pulse is injected ten cycles into a run, and the same cycle counts must still hold. The held results are checked five cycles after done_o, once the operand inputs have changed.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUB  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  logic [DW-1:0] b_x;
  logic [DW:0]   carry;

  assign b_x      = sub_i ? ~b_i : b_i;
  assign carry[0] = sub_i;

  // Explicit ripple chain; the carry out doubles as the no-borrow flag.
  for (genvar g = 0; g < DW; g++) begin : g_fa
    assign sum_o[g]   = a_i[g] ^ b_x[g] ^ carry[g];
    assign carry[g+1] = (a_i[g] & b_x[g]) | (a_i[g] & carry[g]) | (b_x[g] & carry[g]);
  end

  assign cout_o = carry[DW];
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned ITER = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic sub_en_o,
  output logic fix_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned IW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [IW-1:0] LAST = IW'(ITER - 1);

  div_state_e    state_q, state_d;
  logic [IW-1:0] iter_q, iter_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    iter_d  = iter_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SUB;
        iter_d  = '0;
      end
      ST_SUB: state_d = ST_FIX;
      ST_FIX: begin
        if (iter_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_SUB;
          iter_d  = iter_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
      done_q  <= done_d;
    end
  end

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign sub_en_o = (state_q == ST_SUB);
  assign fix_en_o = (state_q == ST_FIX);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sub_en_i,
  input  logic             fix_en_i,
  input  logic             busy_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned DW = 2 * WIDTH;

  logic [DW-1:0]    rem_q, dvs_q, sum;
  logic [WIDTH-1:0] quo_q;
  logic             neg_q, cout;

  div_addsub #(.DW(DW)) i_addsub (
    .a_i   (rem_q),
    .b_i   (dvs_q),
    .sub_i (sub_en_i),
    .sum_o (sum),
    .cout_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= {{WIDTH{1'b0}}, dividend_i};
      dvs_q <= {divisor_i, {WIDTH{1'b0}}};
      quo_q <= '0;
      neg_q <= 1'b0;
    end else if (sub_en_i) begin
      rem_q <= sum;
      neg_q <= ~cout;  // borrow means the trial difference went below zero
    end else if (fix_en_i) begin
      if (neg_q) rem_q <= sum;  // restore by adding the divisor back
      quo_q <= {quo_q[WIDTH-2:0], ~neg_q};
      dvs_q <= dvs_q >> 1;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q[WIDTH-1:0];

  // Between operations the remainder must fit in the low half.
  assert_rem_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (rem_q[DW-1:WIDTH] == '0));
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned ITER   = WIDTH + 1;
  localparam int unsigned CYCLES = 2 * ITER;
  localparam int unsigned CW     = $clog2(CYCLES + 1);

  logic load, sub_en, fix_en;

  div_ctrl #(.ITER(ITER)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .sub_en_o(sub_en),
    .fix_en_o(fix_en),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  div_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .sub_en_i   (sub_en),
    .fix_en_i   (fix_en),
    .busy_i     (busy_o),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o)
  );

  // Busy-cycle counter used only by the latency assertion.
  logic [CW-1:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt_q <= '0;
    else if (!busy_o) busy_cnt_q <= '0;
    else              busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt_q == CW'(CYCLES)));
  assert_busy_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt_q < CW'(CYCLES)));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  assert_hold_results_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/test_seq_restoring_div.sv
`timescale 1ns/1ps
module test_seq_restoring_div;
  localparam int W = 32;
  localparam int CYC = 2 * (W + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic         busy, done;
  logic [W-1:0] quo, rem;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seq_restoring_div #(.WIDTH(W)) i_seq_restoring_div (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem)
  );

  function automatic logic [W-1:0] exp_q(logic [W-1:0] a, logic [W-1:0] b);
    return (b == 0) ? '1 : a / b;
  endfunction
  function automatic logic [W-1:0] exp_r(logic [W-1:0] a, logic [W-1:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One operation; optionally injects a stray start with other operands mid-run (R7).
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dvd = ~a; dvs = b ^ 32'h5A5A_0F0F;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    for (int i = 1; i < CYC; i++) begin
      @(posedge clk);
      if (poke && i == 10) begin
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        i++;
        @(negedge clk);
        start = 1'b0;
      end
    end
    @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, poke ? "R7 timing" : "R3 busy-before-done",
        {busy, done}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, poke ? "R7 done" : "R3 done", {busy, done}, 2'b01);
    if (b == 0) begin
      chk(quo == '1, "R8 quotient", quo, '1);
      chk(rem == a, "R8 remainder", rem, a);
    end else begin
      chk(quo == exp_q(a, b), poke ? "R7 quotient" : "R5 quotient", quo, exp_q(a, b));
      chk(rem == exp_r(a, b), poke ? "R7 remainder" : "R6 remainder", rem, exp_r(a, b));
    end
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse", done, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd7741));
    #12;
    // R1 reset values
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(quo == 0 && rem == 0, "R1 results", {quo, rem}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_div(32'd100, 32'd7, 0);
    run_div(32'd0, 32'd5, 0);
    run_div(32'd3, 32'd9, 0);
    run_div(32'd12345, 32'd12345, 0);
    run_div(32'hFFFF_FFFF, 32'd1, 0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_div(32'hDEAD_BEEF, 32'd0, 0);   // R8
    run_div(32'd0, 32'd0, 0);           // R8
    run_div(32'd1000, 32'd33, 1);       // R7

    // R9: results hold while operands wander
    @(negedge clk);
    a = quo; b = rem;
    dvd = 32'h1234_5678; dvs = 32'h0000_0003;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(quo == a && rem == b && busy == 0, "R9 hold", {quo, rem}, {a, b});

    for (int n = 0; n < 40; n++) begin
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      run_div(a, b, (n % 13) == 5);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule